// File: doc/BRIEF.md
# Self-Refresh Gated Scramble Key Loader

This block installs a fresh memory-scrambling key at a moment when no DRAM contents can be corrupted. A one-cycle start pulse launches a fixed handshake. Every memory controller channel that is in use is first parked in self-refresh. The block then pulls two 32-bit random words from a random-number FIFO and places them in a pair of key registers. It arms the scrambler through its control register, waits a programmable hold time, and then wipes the key registers. It also reads and discards further random words so that the key values do not stay behind in the FIFO. Last, it releases every used channel from self-refresh and waits until all of them report normal operation.

Each channel supplies a mode value, and only its low nibble decides whether the channel takes part. Channels that do not take part receive no commands, and their status is ignored in both waits. When the sequence returns to idle, a single-cycle done pulse is raised.

Top module: `scramKeySequencer`

## Requirements
- R1: A channel takes part only when bits [3:0] of its mode value are nonzero (higher mode bits are ignored); a non-participating channel never sees a command write strobe.
- R2: One cycle after start, each participating channel receives exactly one command write with command value 1 (enter self-refresh).
- R3: No random word is accepted until status bit 0 is 1 on every participating channel; the status of other channels has no effect.
- R4: The ready output is high only while the occupancy field, bits [15:8] of the random status word, is nonzero; a word is accepted in a cycle where ready and valid are both high.
- R5: The first accepted word goes to key register low and the second to key register high.
- R6: After both key words are loaded, the scramble control register is written with 0x00 and then with 0x10 in the next cycle.
- R7: The key registers keep their values for HOLD_CYC+1 cycles after the cycle of the 0x10 write and read zero from the cycle after that.
- R8: After the keys are cleared, exactly four more words are accepted and discarded before any exit command, so a full sequence accepts six words.
- R9: Each participating channel then receives exactly one command write with command value 2 (exit self-refresh); no other command value is ever written.
- R10: The done pulse is one cycle wide and is raised only once status bit 0 reads 0 on every participating channel.
- R11: A start pulse that arrives while a sequence is running is ignored: no repeated commands, no extra words, and a single done.
- R12: After reset, the block is idle: no strobes, ready low, done low, and both key registers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts a key-load sequence when idle |
| donePulse | output | 1 | One-cycle pulse when the sequence returns to idle |
| chanMode | input | NCH*MODEW | Per-channel mode values, channel 0 in the lowest slice |
| srefStat | input | NCH | Per-channel self-refresh status bit |
| srefCmdWr | output | NCH | Per-channel command write strobe |
| srefCmdVal | output | 2 | Command value (1 enter, 2 exit) |
| rngValid | input | 1 | Random word available |
| rngReady | output | 1 | Random word accepted when valid is also high |
| rngData | input | 32 | Random word |
| rngStatus | input | 32 | Random FIFO status word, occupancy at [15:8] |
| keyLo | output | 32 | Key register 0 |
| keyHi | output | 32 | Key register 1 |
| scrCtrlWr | output | 1 | Scramble control write strobe |
| scrCtrlData | output | 8 | Scramble control write value |

## Verification
The bench builds the block with four channels, 8-bit mode values and a hold time of 5 cycles. With a hold this short, the exact cycle of the key wipe can be checked in every run, and a complete sequence is short enough to sweep all sixteen participation masks. In each mask, the unused channels report misleading status and carry nonzero upper mode bits, while the random FIFO model alternates between empty and non-empty and toggles valid. Odd masks also receive extra start pulses during the entry wait and during the hold.

// File: rtl/scramSeqPkg.sv
package scramSeqPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ENTER, S_WAIT_IN, S_KEY0, S_KEY1, S_CTL_CLR, S_CTL_GO,
    S_HOLD, S_CLEAR, S_DRAIN, S_EXIT, S_WAIT_OUT, S_DONE
  } seqState_e;

  typedef struct packed {
    logic latchMask;
    logic cmdEnter;
    logic cmdExit;
    logic fetch;
    logic loadKey0;
    logic loadKey1;
    logic ctlClr;
    logic ctlGo;
    logic holdLoad;
    logic keyClear;
    logic drainLoad;
    logic done;
  } seqStrobe_t;

  localparam logic [1:0] CMD_ENTER = 2'b01;
  localparam logic [1:0] CMD_EXIT  = 2'b10;
  localparam logic [7:0] CTL_IDLE  = 8'h00;
  localparam logic [7:0] CTL_GO    = 8'h10;

endpackage

// File: rtl/scramSeqCtrl.sv
module scramSeqCtrl
  import scramSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       allInSref,
  input  logic       allOutSref,
  input  logic       wordTaken,
  input  logic       holdDone,
  input  logic       drainLast,
  output seqStrobe_t strb
);

  seqState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      S_IDLE: begin
        strb.latchMask = startPulse;
        if (startPulse) nxt = S_ENTER;
      end
      S_ENTER: begin
        strb.cmdEnter = 1'b1;
        nxt = S_WAIT_IN;
      end
      S_WAIT_IN: if (allInSref) nxt = S_KEY0;
      S_KEY0: begin
        strb.fetch    = 1'b1;
        strb.loadKey0 = 1'b1;
        if (wordTaken) nxt = S_KEY1;
      end
      S_KEY1: begin
        strb.fetch    = 1'b1;
        strb.loadKey1 = 1'b1;
        if (wordTaken) nxt = S_CTL_CLR;
      end
      S_CTL_CLR: begin
        strb.ctlClr = 1'b1;
        nxt = S_CTL_GO;
      end
      S_CTL_GO: begin
        strb.ctlGo    = 1'b1;
        strb.holdLoad = 1'b1;
        nxt = S_HOLD;
      end
      S_HOLD: if (holdDone) nxt = S_CLEAR;
      S_CLEAR: begin
        strb.keyClear  = 1'b1;
        strb.drainLoad = 1'b1;
        nxt = S_DRAIN;
      end
      S_DRAIN: begin
        strb.fetch = 1'b1;
        if (wordTaken && drainLast) nxt = S_EXIT;
      end
      S_EXIT: begin
        strb.cmdExit = 1'b1;
        nxt = S_WAIT_OUT;
      end
      S_WAIT_OUT: if (allOutSref) nxt = S_DONE;
      S_DONE: begin
        strb.done = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R10: done never lasts longer than one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);

  // R11: a start seen outside idle does not return the sequencer to entry
  a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_DONE) |=> (state != S_ENTER));

endmodule

// File: rtl/scramSeqPath.sv
module scramSeqPath
  import scramSeqPkg::*;
#(
  parameter int NCH         = 4,
  parameter int MODEW       = 8,
  parameter int WORDW       = 32,
  parameter int HOLD_CYC    = 256,
  parameter int DRAIN_WORDS = 4,
  parameter int OCC_LSB     = 8,
  parameter int OCC_W       = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [NCH*MODEW-1:0] chanMode,
  input  logic [NCH-1:0]     srefStat,
  input  logic               rngValid,
  input  logic [WORDW-1:0]   rngData,
  input  logic [WORDW-1:0]   rngStatus,
  output logic               allInSref,
  output logic               allOutSref,
  output logic               wordTaken,
  output logic               holdDone,
  output logic               drainLast,
  output logic [NCH-1:0]     srefCmdWr,
  output logic [1:0]         srefCmdVal,
  output logic               rngReady,
  output logic [WORDW-1:0]   keyLo,
  output logic [WORDW-1:0]   keyHi,
  output logic               scrCtrlWr,
  output logic [7:0]         scrCtrlData,
  output logic               donePulse
);

  localparam int ACT_BITS = 4;
  localparam int HOLD_W   = $clog2(HOLD_CYC + 1);
  localparam int DRAIN_W  = $clog2(DRAIN_WORDS + 1);

  logic [NCH-1:0]     activeNow;
  logic [NCH-1:0]     activeMask;
  logic [HOLD_W-1:0]  holdCnt;
  logic [DRAIN_W-1:0] drainCnt;
  logic               occNonzero;
  logic               unusedStat;
  logic [NCH-1:0]     unusedMode;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chan
      assign activeNow[gi]  = |chanMode[gi*MODEW +: ACT_BITS];
      if (MODEW > ACT_BITS) begin : g_hi
        assign unusedMode[gi] = ^chanMode[gi*MODEW+ACT_BITS +: MODEW-ACT_BITS];
      end else begin : g_nohi
        assign unusedMode[gi] = 1'b0;
      end
    end
  endgenerate

  assign unusedStat = ^{rngStatus[WORDW-1:OCC_LSB+OCC_W], rngStatus[OCC_LSB-1:0], unusedMode};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               activeMask <= '0;
    else if (strb.latchMask) activeMask <= activeNow;
  end

  assign allInSref  = &(srefStat | ~activeMask);
  assign allOutSref = ~|(srefStat & activeMask);

  assign occNonzero = |rngStatus[OCC_LSB +: OCC_W];
  assign rngReady   = strb.fetch && occNonzero;
  assign wordTaken  = rngReady && rngValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyLo <= '0;
      keyHi <= '0;
    end else if (strb.keyClear) begin
      keyLo <= '0;
      keyHi <= '0;
    end else if (wordTaken) begin
      if (strb.loadKey0) keyLo <= rngData;
      if (strb.loadKey1) keyHi <= rngData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strb.holdLoad)   holdCnt <= HOLD_W'(HOLD_CYC - 1);
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end
  assign holdDone = (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               drainCnt <= '0;
    else if (strb.drainLoad)                 drainCnt <= DRAIN_W'(DRAIN_WORDS - 1);
    else if (wordTaken && drainCnt != '0)    drainCnt <= drainCnt - 1'b1;
  end
  assign drainLast = (drainCnt == '0);

  assign srefCmdWr   = activeMask & {NCH{strb.cmdEnter | strb.cmdExit}};
  assign srefCmdVal  = strb.cmdExit ? CMD_EXIT : (strb.cmdEnter ? CMD_ENTER : 2'b00);
  assign scrCtrlWr   = strb.ctlClr | strb.ctlGo;
  assign scrCtrlData = strb.ctlGo ? CTL_GO : CTL_IDLE;
  assign donePulse   = strb.done;

  // R6: the arming write always directly follows the clearing write
  a_r6_go_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    (scrCtrlWr && scrCtrlData == CTL_GO) |->
      ($past(scrCtrlWr) && $past(scrCtrlData) == CTL_IDLE));

  // R7: keys do not move while the hold counter runs
  a_r7_keys_held: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0) |=> ($stable(keyLo) && $stable(keyHi)));

  // R8: exit is commanded only right after the last drain word
  a_r8_exit_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdExit |-> ($past(wordTaken) && $past(drainCnt) == '0));

endmodule

// File: rtl/scramKeySequencer.sv
module scramKeySequencer
  import scramSeqPkg::*;
#(
  parameter int NCH         = 4,
  parameter int MODEW       = 8,
  parameter int HOLD_CYC    = 256,
  parameter int DRAIN_WORDS = 4
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  output logic                 donePulse,
  input  logic [NCH*MODEW-1:0] chanMode,
  input  logic [NCH-1:0]       srefStat,
  output logic [NCH-1:0]       srefCmdWr,
  output logic [1:0]           srefCmdVal,
  input  logic                 rngValid,
  output logic                 rngReady,
  input  logic [31:0]          rngData,
  input  logic [31:0]          rngStatus,
  output logic [31:0]          keyLo,
  output logic [31:0]          keyHi,
  output logic                 scrCtrlWr,
  output logic [7:0]           scrCtrlData
);

  seqStrobe_t strb;
  logic allInSref, allOutSref, wordTaken, holdDone, drainLast;
  logic [NCH-1:0] liveActive;

  scramSeqCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .allInSref  (allInSref),
    .allOutSref (allOutSref),
    .wordTaken  (wordTaken),
    .holdDone   (holdDone),
    .drainLast  (drainLast),
    .strb       (strb)
  );

  scramSeqPath #(
    .NCH         (NCH),
    .MODEW       (MODEW),
    .WORDW       (32),
    .HOLD_CYC    (HOLD_CYC),
    .DRAIN_WORDS (DRAIN_WORDS),
    .OCC_LSB     (8),
    .OCC_W       (8)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .chanMode    (chanMode),
    .srefStat    (srefStat),
    .rngValid    (rngValid),
    .rngData     (rngData),
    .rngStatus   (rngStatus),
    .allInSref   (allInSref),
    .allOutSref  (allOutSref),
    .wordTaken   (wordTaken),
    .holdDone    (holdDone),
    .drainLast   (drainLast),
    .srefCmdWr   (srefCmdWr),
    .srefCmdVal  (srefCmdVal),
    .rngReady    (rngReady),
    .keyLo       (keyLo),
    .keyHi       (keyHi),
    .scrCtrlWr   (scrCtrlWr),
    .scrCtrlData (scrCtrlData),
    .donePulse   (donePulse)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_live
      assign liveActive[gi] = |chanMode[gi*MODEW +: 4];
    end
  endgenerate

  // R1: command strobes reach only channels whose mode nibble is nonzero
  a_r1_cmd_active_only: assert property (@(posedge clk) disable iff (!rstN)
    (|srefCmdWr) |-> ((srefCmdWr & ~liveActive) == '0));

endmodule

// File: tb/sim_scramKeySequencer.sv
`timescale 1ns/1ps
module sim_scramKeySequencer;

  localparam int NCH  = 4;
  localparam int HOLD = 5;
  localparam logic [31:0] BASE = 32'hA500_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic donePulse;
  logic [NCH*8-1:0] chanMode = '0;
  logic [NCH-1:0] srefStat = '0;
  logic [NCH-1:0] srefCmdWr;
  logic [1:0] srefCmdVal;
  logic rngValid = 1'b0;
  logic rngReady;
  logic [31:0] rngData = '0;
  logic [31:0] rngStatus = '0;
  logic [31:0] keyLo, keyHi;
  logic scrCtrlWr;
  logic [7:0] scrCtrlData;

  always #2 clk = ~clk;

  scramKeySequencer #(.NCH(NCH), .MODEW(8), .HOLD_CYC(HOLD), .DRAIN_WORDS(4)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .donePulse(donePulse),
    .chanMode(chanMode), .srefStat(srefStat), .srefCmdWr(srefCmdWr),
    .srefCmdVal(srefCmdVal), .rngValid(rngValid), .rngReady(rngReady),
    .rngData(rngData), .rngStatus(rngStatus), .keyLo(keyLo), .keyHi(keyHi),
    .scrCtrlWr(scrCtrlWr), .scrCtrlData(scrCtrlData)
  );

  int nChecks = 0, nFails = 0;
  int cyc = 0, wordIdx = 0;
  bit pendTake = 0, startReq = 0, timedOut = 0;
  bit [NCH-1:0] active, modelStat;
  int cd[NCH], enterCnt[NCH], exitCnt[NCH];
  bit tgt[NCH];
  bit goSeen, restartRun, prevDone;
  bit r1Bad, r3Bad, r4Bad, r9Bad, r10Bad, keyHeldOk, keyZeroOk;
  int takes, takesAtExit, ctlCnt, ctl0Cyc, ctl1Cyc, goCyc, doneCnt, runCyc;
  logic [7:0] ctl0Data, ctl1Data;
  logic [31:0] k0, k1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    logic [7:0] occ;
    bit take;
    @(negedge clk);
    cyc++;
    runCyc++;
    if (cyc > 150000) timedOut = 1;
    if (pendTake) wordIdx++;
    startPulse = startReq;
    startReq = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (cd[ch] > 0) begin
        cd[ch]--;
        if (cd[ch] == 0) modelStat[ch] = tgt[ch];
      end
      srefStat[ch] = active[ch] ? modelStat[ch] : goSeen;
    end
    occ = (cyc % 5 < 2) ? 8'd0 : 8'd3;
    rngStatus = {16'hFFFF, occ, 8'hFF};
    rngValid = (cyc % 3 != 0);
    rngData = BASE + 32'(wordIdx);
    #1;
    if (rngReady && occ == 0) r4Bad = 1;
    take = rngReady && rngValid;
    pendTake = take;
    if (take) begin
      if (takes == 0 && ((modelStat & active) != active)) r3Bad = 1;
      takes++;
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (srefCmdWr[ch]) begin
        if (!active[ch]) r1Bad = 1;
        if (srefCmdVal == 2'd1) begin
          enterCnt[ch]++; cd[ch] = 1 + (ch + cyc) % 3; tgt[ch] = 1;
        end else if (srefCmdVal == 2'd2) begin
          exitCnt[ch]++; takesAtExit = takes; cd[ch] = 1 + (ch + cyc) % 4; tgt[ch] = 0;
        end else r9Bad = 1;
      end
    end
    if (scrCtrlWr) begin
      ctlCnt++;
      if (ctlCnt == 1) begin ctl0Data = scrCtrlData; ctl0Cyc = cyc; end
      else if (ctlCnt == 2) begin
        ctl1Data = scrCtrlData; ctl1Cyc = cyc; goCyc = cyc; goSeen = 1;
        k0 = keyLo; k1 = keyHi;
      end
    end
    if (goSeen && cyc == goCyc + HOLD + 1) keyHeldOk = (keyLo == k0) && (keyHi == k1);
    if (goSeen && cyc == goCyc + HOLD + 2) keyZeroOk = (keyLo == 0) && (keyHi == 0);
    if (restartRun && (runCyc == 3 || (goSeen && cyc == goCyc + 2))) startReq = 1;
    if (donePulse) begin
      doneCnt++;
      if ((modelStat & active) != 0) r10Bad = 1;
      if (prevDone) r10Bad = 1;
    end
    prevDone = donePulse;
  endtask

  task automatic runOne(input int mask, input bit restart);
    int startIdx, extra, nAct;
    active = mask[NCH-1:0];
    for (int ch = 0; ch < NCH; ch++) begin
      chanMode[ch*8 +: 8] = active[ch] ? {4'hA, 4'(1 + (ch + mask) % 15)} : {4'(5 + ch), 4'h0};
      cd[ch] = 0; enterCnt[ch] = 0; exitCnt[ch] = 0; tgt[ch] = 0;
    end
    modelStat = '0; goSeen = 0; restartRun = restart; prevDone = 0;
    r1Bad = 0; r3Bad = 0; r4Bad = 0; r9Bad = 0; r10Bad = 0; keyHeldOk = 0; keyZeroOk = 0;
    takes = 0; takesAtExit = -1; ctlCnt = 0; ctl0Cyc = 0; ctl1Cyc = 0; goCyc = 0;
    doneCnt = 0; runCyc = 0; ctl0Data = 8'hFF; ctl1Data = 8'hFF; k0 = 0; k1 = 0;
    startIdx = wordIdx + (pendTake ? 1 : 0);
    startReq = 1;
    extra = 0;
    while (extra < 5 && runCyc < 2000 && !timedOut) begin
      step();
      if (doneCnt > 0) extra++;
    end
    nAct = $countones(active);
    check(runCyc < 2000 && !timedOut, "R10", "run finished (watchdog)", runCyc, 2000);
    check(!r1Bad, "R1", $sformatf("no strobe to unused channel mask=%0h", mask), r1Bad, 0);
    for (int ch = 0; ch < NCH; ch++) begin
      check(enterCnt[ch] == (active[ch] ? 1 : 0), "R2", $sformatf("enter writes ch%0d mask=%0h", ch, mask),
            enterCnt[ch], active[ch]);
      check(exitCnt[ch] == (active[ch] ? 1 : 0), "R9", $sformatf("exit writes ch%0d mask=%0h", ch, mask),
            exitCnt[ch], active[ch]);
    end
    check(!r3Bad, "R3", $sformatf("first word after entry mask=%0h", mask), r3Bad, 0);
    check(!r4Bad, "R4", $sformatf("ready with empty fifo mask=%0h", mask), r4Bad, 0);
    check(k0 == BASE + 32'(startIdx), "R5", "key low word", k0, BASE + 32'(startIdx));
    check(k1 == BASE + 32'(startIdx + 1), "R5", "key high word", k1, BASE + 32'(startIdx + 1));
    check(ctlCnt == 2 && ctl0Data == 8'h00 && ctl1Data == 8'h10 && ctl1Cyc == ctl0Cyc + 1,
          "R6", "control write pair", {ctl0Data, ctl1Data}, 16'h0010);
    check(keyHeldOk, "R7", "keys held through hold", keyLo, k0);
    check(keyZeroOk, "R7", "keys wiped after hold", keyLo, 0);
    check(takes == 6 && (nAct == 0 || takesAtExit == 6), "R8", "words taken before exit",
          takesAtExit, 6);
    check(!r9Bad, "R9", "no stray command value", r9Bad, 0);
    check(doneCnt == 1 && !r10Bad, "R10", $sformatf("single done after release mask=%0h", mask),
          doneCnt, 1);
    if (restart)
      check(doneCnt == 1 && takes == 6, "R11", $sformatf("busy start ignored mask=%0h", mask),
            takes, 6);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!donePulse && srefCmdWr == 0 && !rngReady && !scrCtrlWr, "R12", "strobes idle in reset",
          {donePulse, srefCmdWr, rngReady, scrCtrlWr}, 0);
    check(keyLo == 0 && keyHi == 0, "R12", "keys zero in reset", keyLo | keyHi, 0);
    @(negedge clk);
    rstN = 1'b1;
    step();
    check(!donePulse && srefCmdWr == 0 && !rngReady, "R12", "idle after reset",
          {donePulse, srefCmdWr, rngReady}, 0);
    for (int m = 0; m < 16; m++) begin
      if (!timedOut) runOne(m, m[0]);
    end
    if (timedOut) check(0, "R10", "global watchdog", cyc, 150000);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule